// File: doc/BRIEF.md
# Serial-wire / JTAG port mode selector

This block sits on the target side of a debug port whose mode line is shared between JTAG (where it acts as TMS) and the serial-wire protocol (where it acts as SWDIO). It samples that line on every rising edge of the debug clock and decides which protocol engine owns the port. It also tells the protocol logic when the line is holding everything in reset.

A reset run is a stretch of at least `RUN_LEN` (default 50) consecutive high samples. While the line stays high after such a run, `line_rst_o` is held high. The first low bit after a complete run opens a 16-bit capture window, and the bits are collected least-significant first. At the end of the window the word is compared against three switch codes:

- 0xE73C selects JTAG.
- 0xDEAE selects JTAG. This is the older code, whose bytes arrive as 0xAE and then 0xDE.
- 0xE79E selects serial-wire.

Any other word is discarded. Detection runs in both modes. A mode change produces a one-cycle reset pulse towards the newly selected engine. After power-on reset the port starts in JTAG.

Top module: `swj_mode_detect`

## Requirements
- R1: While rst_ni is low, and afterwards until a valid switch, mode_o is 0 (0 = JTAG, 1 = serial-wire). After reset, line_rst_o, jtag_rst_o and swd_rst_o are all 0.
- R2: line_rst_o goes to 1 after the rising edge that samples the RUN_LEN-th consecutive high bit. It stays 1 for any number of further high bits, because the count saturates.
- R3: A low sample clears the run count. line_rst_o is 0 after that edge, and RUN_LEN-1 highs that follow a low do not raise it.
- R4: The 16-bit word 0xE73C, taken LSB first straight after a complete reset run, sets mode_o to 0. The capture starts with the low bit that ends the run.
- R5: The word 0xDEAE under the same framing also sets mode_o to 0.
- R6: The word 0xE79E under the same framing sets mode_o to 1, whichever mode is current.
- R7: A switch code that is not preceded by at least RUN_LEN consecutive highs is ignored, and mode_o is unchanged.
- R8: A mode change raises swd_rst_o (change to 1) or jtag_rst_o (change to 0) for exactly one cycle. The pulse appears after the edge that samples the 16th code bit. A code that selects the current mode raises no pulse.
- R9: A captured word that matches no switch code leaves mode_o unchanged and raises no pulse.
- R10: After a switch, a following reset run raises line_rst_o again, and the new mode is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Debug clock; the line is sampled on rising edges |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| line_i | input | 1 | Shared mode/data line value |
| mode_o | output | 1 | Current port mode, 0 = JTAG, 1 = serial-wire |
| line_rst_o | output | 1 | High while a completed reset run is in progress |
| jtag_rst_o | output | 1 | One-cycle reset to the JTAG engine on a change to JTAG |
| swd_rst_o | output | 1 | One-cycle reset to the serial-wire engine on a change to serial-wire |

## Verification
The switch detector is tried with each of the three codes, sent from both modes. This separates a real mode change, which must raise a pulse, from a repeat request for the current mode, which must not. Runs of exactly 49 highs and of 50 or more highs are placed before the codes, which pins down the framing threshold. A non-matching word after a valid run shows that the comparison, and not the capture alone, drives the mode. Run lengths of 49, 50 and 70 highs, and a low bit in the middle of a run, check the saturating count behind line_rst_o.

// File: rtl/swj_pkg.sv
package swj_pkg;
  typedef enum logic {
    MODE_JTAG = 1'b0,
    MODE_SWD  = 1'b1
  } port_mode_e;

  localparam int unsigned SEQ_W = 16;

  localparam logic [SEQ_W-1:0] CODE_TO_JTAG     = 16'hE73C;
  localparam logic [SEQ_W-1:0] CODE_TO_JTAG_OLD = 16'hDEAE;
  localparam logic [SEQ_W-1:0] CODE_TO_SWD      = 16'hE79E;
endpackage

// File: rtl/swj_run_counter.sv
module swj_run_counter #(
  parameter int unsigned RUN_LEN = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  input  logic hold_i,
  output logic run_done_o
);
  localparam int unsigned CNT_W = $clog2(RUN_LEN + 1);
  localparam logic [CNT_W-1:0] RUN_MAX = CNT_W'(RUN_LEN);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!line_i || hold_i) cnt_q <= '0;
    else if (cnt_q != RUN_MAX)  cnt_q <= cnt_q + 1'b1;
  end

  assign run_done_o = (cnt_q == RUN_MAX);

  assert_run_sat_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= RUN_MAX);

  // once saturated, a further high keeps the run complete
  assert_run_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_done_o && line_i && !hold_i) |=> run_done_o);
endmodule

// File: rtl/swj_seq_capture.sv
module swj_seq_capture #(
  parameter int unsigned SEQ_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_i,
  input  logic             run_done_i,
  output logic             busy_o,
  output logic [SEQ_W-1:0] word_o,
  output logic             word_vld_o
);
  localparam int unsigned IDX_W = $clog2(SEQ_W);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(SEQ_W - 1);

  logic             capt_q;
  logic [IDX_W-1:0] idx_q;
  logic [SEQ_W-1:0] sh_q;
  logic [SEQ_W-1:0] sh_next;

  // LSB-first: newest bit enters at the top
  assign sh_next = {line_i, sh_q[SEQ_W-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      capt_q <= 1'b0;
      idx_q  <= '0;
      sh_q   <= '0;
    end else if (!capt_q) begin
      // window opens on the low bit that ends a complete run
      if (run_done_i && !line_i) begin
        capt_q <= 1'b1;
        idx_q  <= IDX_W'(1);
        sh_q   <= sh_next;
      end
    end else begin
      sh_q <= sh_next;
      if (idx_q == IDX_LAST) begin
        capt_q <= 1'b0;
        idx_q  <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign busy_o     = capt_q;
  assign word_o     = sh_next;
  assign word_vld_o = capt_q && (idx_q == IDX_LAST);

  assert_start_framed_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!capt_q && !run_done_i) |=> !capt_q);

  assert_idx_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capt_q |-> (idx_q == '0));
endmodule

// File: rtl/swj_mode_detect.sv
module swj_mode_detect #(
  parameter int unsigned RUN_LEN = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic mode_o,
  output logic line_rst_o,
  output logic jtag_rst_o,
  output logic swd_rst_o
);
  import swj_pkg::*;

  logic             run_done;
  logic             capt_busy;
  logic [SEQ_W-1:0] word;
  logic             word_vld;
  logic             hit_jtag;
  logic             hit_swd;
  port_mode_e       mode_q;
  logic             jtag_rst_q;
  logic             swd_rst_q;

  swj_run_counter #(.RUN_LEN(RUN_LEN)) u_run (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .line_i     (line_i),
    .hold_i     (capt_busy),
    .run_done_o (run_done)
  );

  swj_seq_capture #(.SEQ_W(SEQ_W)) u_capt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .line_i     (line_i),
    .run_done_i (run_done),
    .busy_o     (capt_busy),
    .word_o     (word),
    .word_vld_o (word_vld)
  );

  assign hit_jtag = word_vld && ((word == CODE_TO_JTAG) || (word == CODE_TO_JTAG_OLD));
  assign hit_swd  = word_vld && (word == CODE_TO_SWD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= MODE_JTAG;
      jtag_rst_q <= 1'b0;
      swd_rst_q  <= 1'b0;
    end else begin
      jtag_rst_q <= hit_jtag && (mode_q == MODE_SWD);
      swd_rst_q  <= hit_swd  && (mode_q == MODE_JTAG);
      if (hit_jtag)     mode_q <= MODE_JTAG;
      else if (hit_swd) mode_q <= MODE_SWD;
    end
  end

  assign mode_o     = mode_q;
  assign line_rst_o = run_done;
  assign jtag_rst_o = jtag_rst_q;
  assign swd_rst_o  = swd_rst_q;

  assert_low_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_i |=> !line_rst_o);

  assert_pulse_onehot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({jtag_rst_o, swd_rst_o}));

  assert_pulse_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jtag_rst_o || swd_rst_o) |=> !(jtag_rst_o || swd_rst_o));

  assert_change_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != $past(mode_o)) |-> (mode_o ? swd_rst_o : jtag_rst_o));

  assert_hold_mode_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_vld |=> $stable(mode_o));
endmodule

// File: tb/swj_mode_detect_tb.sv
`timescale 1ns/1ps
module swj_mode_detect_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line = 1'b0;
  logic mode, line_rst, jtag_rst, swd_rst;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  swj_mode_detect #(.RUN_LEN(50)) u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .line_i     (line),
    .mode_o     (mode),
    .line_rst_o (line_rst),
    .jtag_rst_o (jtag_rst),
    .swd_rst_o  (swd_rst)
  );

  // {highs[25:19], code[18:3], exp_mode[2], exp_swd_pulse[1], exp_jtag_pulse[0]}
  localparam int NV = 9;
  localparam logic [25:0] VEC [NV] = '{
    {7'd50, 16'hE79E, 3'b110},  // R6 JTAG->SWD
    {7'd60, 16'hE79E, 3'b100},  // R8 same mode, no pulse
    {7'd50, 16'hE73C, 3'b001},  // R4 SWD->JTAG
    {7'd55, 16'hE79E, 3'b110},  // R6
    {7'd50, 16'hDEAE, 3'b001},  // R5 older code
    {7'd48, 16'hE79E, 3'b000},  // R7 48 + 1 trailing high = 49, ignored
    {7'd50, 16'h1234, 3'b000},  // R9 no match
    {7'd50, 16'hE79E, 3'b110},  // R6
    {7'd50, 16'hE73C, 3'b001}   // R4
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk) line = b;
    @(posedge clk);
    #1;
  endtask

  task automatic send_ones(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b1);
  endtask

  task automatic send_code(input logic [15:0] c);
    for (int i = 0; i < 16; i++) send_bit(c[i]);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 mode in reset", mode, 0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 mode", mode, 0);
    chk("R1 line_rst", line_rst, 0);
    chk("R1 pulses", {jtag_rst, swd_rst}, 0);

    send_ones(30);
    send_bit(1'b0);
    chk("R3 low clears", line_rst, 0);
    send_ones(49);
    chk("R3 49 highs after low", line_rst, 0);
    send_ones(1);
    chk("R2 50th high", line_rst, 1);
    send_ones(20);
    chk("R2 saturated run", line_rst, 1);

    for (int v = 0; v < NV; v++) begin
      send_ones(int'(VEC[v][25:19]));
      send_code(VEC[v][18:3]);
      chk($sformatf("R4/R5/R6/R7/R9 mode vec%0d", v), mode, VEC[v][2]);
      chk($sformatf("R8 swd pulse vec%0d", v), swd_rst, VEC[v][1]);
      chk($sformatf("R8 jtag pulse vec%0d", v), jtag_rst, VEC[v][0]);
      send_bit(1'b1);
      chk($sformatf("R8 pulse ends vec%0d", v), {jtag_rst, swd_rst}, 0);
      chk($sformatf("R8 mode held vec%0d", v), mode, VEC[v][2]);
    end

    send_ones(50);
    chk("R10 line_rst after switch", line_rst, 1);
    chk("R10 mode kept", mode, 0);
    send_bit(1'b0);
    chk("R3 low ends reset", line_rst, 0);

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule